// File: doc/BRIEF.md
# Fractional Tick Divider

This block turns a stream of source-clock enable pulses into a slower tick strobe for pulse-generation channels that share it. The ratio is an integer part plus one plus a fraction: the number of source pulses per tick period is `int + 1`, and some periods get one extra pulse. The source is chosen from three enable inputs: the bus clock, the internal 20 MHz oscillator or the external crystal. The block has no clock muxing of its own. Each source appears as a one-cycle enable in the block's single clock domain.

A fractional accumulator produces the fraction. At the start of every tick period it adds the numerator. When the sum reaches the denominator it subtracts the denominator, and that period is one source pulse longer. Over `den` periods this spreads `num` extra pulses evenly. A denominator of zero turns the fraction off.

A one-cycle load strobe captures new settings. Settings that are out of range are refused and flagged, and the settings already running stay in use. A setting that is accepted waits in a staging register and takes over only where a tick period ends, so a period in progress is never cut short.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held and after it is released, `tick` and `cfg_err` are 0. The settings in use are all zero (select 0, int 0, num 0, den 0), so every bus-source pulse yields a tick.
- R2: `tick` is high for exactly the one cycle after the source pulse that completes a period. With `den` = 0 every period lasts `int + 1` source pulses and `num` has no effect.
- R3: With `den` > 0, each period first adds `num` to the accumulator. When the sum is at least `den`, `den` is subtracted and that period lasts `int + 2` pulses; otherwise it lasts `int + 1`. For example, int 2 with 1/2 gives periods of 3 and then 4 pulses after the settings take over. Over the `den` periods that start where the settings take over, the total is `den*(int+1) + num` pulses.
- R4: Select codes 0 and 1 count `src_bus_en`, code 2 counts `src_osc_en` and code 3 counts `src_xtal_en`. The enables that are not selected have no effect on `tick`.
- R5: A load with `cfg_num` > 64, with `cfg_den` > 64, or with `cfg_den` ≠ 0 and `cfg_num` > `cfg_den` is refused. `cfg_err` reads 1 from the cycle after that load, and the settings already running keep producing the same ticks.
- R6: A load that is accepted sets `cfg_err` to 0 from the cycle after it.
- R7: Accepted settings take over at the first period end after the load cycle. The period running at the time of the load keeps its old length.
- R8: An accepted load clears the accumulator to 0, so the first period under the new settings is stretched only if `num` equals `den`.
- R9: The integer part covers its full 8-bit range: int 255 with 1/2 gives 513 pulses over two periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_bus_en | input | 1 | One-cycle enable of the bus clock source |
| src_osc_en | input | 1 | One-cycle enable of the 20 MHz oscillator source |
| src_xtal_en | input | 1 | One-cycle enable of the crystal source |
| cfg_load | input | 1 | Strobe that captures the settings fields |
| cfg_src_sel | input | 2 | Source select: 0/1 bus, 2 oscillator, 3 crystal |
| cfg_int | input | 8 | Integer part of the ratio |
| cfg_num | input | 7 | Fraction numerator |
| cfg_den | input | 7 | Fraction denominator, 0 turns the fraction off |
| tick | output | 1 | One-cycle tick strobe |
| cfg_err | output | 1 | The last load was refused |

## Verification
The hardest state to reach from the ports is a live period whose length was already fixed by the old accumulator, with the accumulator left at a non-zero remainder, at the moment a reload arrives. The stimulus runs int 2 with 1/2 for exactly one short period and one long period. It then stops the sources, reloads the same settings and resumes. The period right after the handover must then be short (3 pulses), which shows that the load cleared the remainder. A second hard case is a load that lands part-way through a period. The bench drives the load in the cycle right after a tick and checks that the old 4-pulse length still holds before the new 1-pulse spacing starts. The table drives the selected source every other cycle while holding the others high, so any leak from an enable that is not selected shows up as a wrong count.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  parameter int INT_W      = 8;
  parameter int FRAC_W     = 7;
  parameter int FRAC_LIMIT = 64;
  parameter int SEL_W      = 2;
  localparam int CNT_W     = INT_W + 1;
  localparam int ACC_W     = FRAC_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] num;
    logic [FRAC_W-1:0] den;
  } div_cfg_t;

  localparam logic [SEL_W-1:0] SEL_OSC  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_XTAL = SEL_W'(3);
endpackage

// File: rtl/fcd_cfg_stage.sv
module fcd_cfg_stage
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  div_cfg_t cfg_in,
  input  logic     apply,
  output div_cfg_t active_q,
  output div_cfg_t next_cfg,
  output logic     accepted,
  output logic     err_q
);
  localparam logic [FRAC_W-1:0] LIM = FRAC_W'(FRAC_LIMIT);

  div_cfg_t pend_q, pend_d, active_d;
  logic     pend_v_q, pend_v_d, err_d, valid;

  always_comb begin
    valid = (cfg_in.num <= LIM) && (cfg_in.den <= LIM) &&
            ((cfg_in.den == '0) || (cfg_in.num <= cfg_in.den));
    accepted = load && valid;
    next_cfg = pend_v_q ? pend_q : active_q;
  end

  always_comb begin
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    active_d = active_q;
    err_d    = err_q;
    if (apply && pend_v_q) begin
      active_d = pend_q;
      pend_v_d = 1'b0;
    end
    if (load) begin
      err_d = !valid;
      if (valid) begin
        pend_d   = cfg_in;
        pend_v_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      active_q <= '0;
      err_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  assert_err_only_by_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(load));
  assert_refused_keeps_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !valid) |=> $stable(pend_q));
  assert_switch_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active_q));
endmodule

// File: rtl/fcd_frac_acc.sv
module fcd_frac_acc
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              stretch
);
  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum     = acc_q + ACC_W'(num);
    stretch = (den != '0) && (sum >= ACC_W'(den));
    acc_d   = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (step) begin
      if (den == '0)   acc_d = '0;
      else if (stretch) acc_d = sum - ACC_W'(den);
      else             acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_rem_below_den_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && den != '0) |=> (acc_q < ACC_W'($past(den))));
endmodule

// File: rtl/fcd_period_cnt.sv
module fcd_period_cnt
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic [CNT_W-1:0] last_next,
  output logic             boundary,
  output logic             tick_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last_q, last_d;

  always_comb begin
    boundary = pulse && (cnt_q == last_q);
    cnt_d    = cnt_q;
    last_d   = last_q;
    if (pulse) cnt_d = boundary ? '0 : cnt_q + 1'b1;
    if (boundary) last_d = last_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      tick_q <= boundary;
    end
  end

  assert_tick_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(pulse));
  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_bus_en,
  input  logic              src_osc_en,
  input  logic              src_xtal_en,
  input  logic              cfg_load,
  input  logic [SEL_W-1:0]  cfg_src_sel,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              tick,
  output logic              cfg_err
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  div_cfg_t cfg_in, active_cfg, next_cfg;
  logic     accepted, boundary, stretch, pulse;
  logic [CNT_W-1:0] last_next;

  always_comb begin
    cfg_in.sel     = cfg_src_sel;
    cfg_in.div_int = cfg_int;
    cfg_in.num     = cfg_num;
    cfg_in.den     = cfg_den;
    case (active_cfg.sel)
      SEL_OSC:  pulse = src_osc_en;
      SEL_XTAL: pulse = src_xtal_en;
      default:  pulse = src_bus_en;
    endcase
    last_next = CNT_W'(next_cfg.div_int) + CNT_W'(stretch);
  end

  fcd_cfg_stage u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (cfg_load),
    .cfg_in   (cfg_in),
    .apply    (boundary),
    .active_q (active_cfg),
    .next_cfg (next_cfg),
    .accepted (accepted),
    .err_q    (cfg_err)
  );

  fcd_frac_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_sync),
    .clear   (accepted),
    .step    (boundary),
    .num     (next_cfg.num),
    .den     (next_cfg.den),
    .stretch (stretch)
  );

  fcd_period_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync),
    .pulse     (pulse),
    .last_next (last_next),
    .boundary  (boundary),
    .tick_q    (tick)
  );

  assert_no_tick_in_reset_R1: assert property (@(posedge clk)
    !rst_sync |=> !tick);
endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
  logic clk = 1'b0;
  logic rst_n, src_bus_en, src_osc_en, src_xtal_en, cfg_load;
  logic [1:0] cfg_src_sel;
  logic [7:0] cfg_int;
  logic [6:0] cfg_num, cfg_den;
  logic tick, cfg_err;
  int n_checks = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  frac_clk_div uut (
    .clk(clk), .rst_n(rst_n), .src_bus_en(src_bus_en), .src_osc_en(src_osc_en),
    .src_xtal_en(src_xtal_en), .cfg_load(cfg_load), .cfg_src_sel(cfg_src_sel),
    .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_den(cfg_den),
    .tick(tick), .cfg_err(cfg_err)
  );

  typedef struct packed {
    int sel; int dint; int num; int den; int gap; int exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TBL [NVEC] = '{
    '{0, 0,   0,  0,  2, 8},
    '{1, 3,   0,  0,  1, 16},
    '{2, 2,   1,  2,  1, 7},
    '{3, 0,   1,  3,  2, 8},
    '{1, 4,   3,  4,  1, 23},
    '{2, 1,   5,  5,  1, 15},
    '{3, 0,   64, 64, 1, 128},
    '{1, 255, 1,  2,  1, 513},
    '{2, 0,   7,  0,  2, 8},
    '{1, 9,   63, 64, 1, 703}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_src(input int sel, input bit p);
    src_bus_en  = (sel <= 1) ? p : 1'b1;
    src_osc_en  = (sel == 2) ? p : 1'b1;
    src_xtal_en = (sel == 3) ? p : 1'b1;
  endtask

  task automatic src_off(input int n);
    src_bus_en = 0; src_osc_en = 0; src_xtal_en = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int sel, input int dint, input int num, input int den);
    cfg_src_sel = 2'(sel); cfg_int = 8'(dint);
    cfg_num = 7'(num); cfg_den = 7'(den);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
  endtask

  // Waits for the tick where new settings take over, then counts cycles over nper periods.
  task automatic run_periods(input int sel, input int gap, input int nper,
                             output int total, output int first);
    int cyc = 0;
    int seen = 0;
    first = 0;
    drive_src(3, 1'b1);
    @(negedge clk);
    while (!tick) @(negedge clk);
    while (seen < nper) begin
      drive_src(sel, (cyc % gap) == gap - 1);
      @(negedge clk);
      cyc++;
      if (tick) begin
        seen++;
        if (seen == 1) first = cyc;
      end
    end
    total = cyc;
    drive_src(3, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    int total, first, cyc, cnt;
    rst_n = 0; cfg_load = 0; cfg_src_sel = 0; cfg_int = 0; cfg_num = 0; cfg_den = 0;
    src_bus_en = 1; src_osc_en = 1; src_xtal_en = 1;
    repeat (5) @(negedge clk);
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(cfg_err == 1'b0, "R1 err in reset", int'(cfg_err), 0);
    src_bus_en = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R4: with default select only the bus enable counts
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 0, "R4 default ignores osc/xtal", cnt, 0);
    check(cfg_err == 1'b0, "R1 err after reset", int'(cfg_err), 0);
    run_periods(0, 1, 4, total, first);
    check(total == 4, "R1 default divide by one", total, 4);

    // Table walk: R2 R3 R4 R9
    for (int v = 0; v < NVEC; v++) begin
      src_off(2);
      do_load(TBL[v].sel, TBL[v].dint, TBL[v].num, TBL[v].den);
      check(cfg_err == 1'b0, "R6 valid load no err", int'(cfg_err), 0);
      run_periods(TBL[v].sel, TBL[v].gap, (TBL[v].den == 0) ? 4 : TBL[v].den, total, first);
      check(total == TBL[v].exp, $sformatf("R3 table entry %0d", v), total, TBL[v].exp);
    end

    // R5: refused loads keep the running settings
    src_off(2);
    do_load(1, 3, 0, 0);
    run_periods(1, 1, 4, total, first);
    check(total == 16, "R2 int3 baseline", total, 16);
    src_off(2);
    do_load(2, 0, 65, 0);
    check(cfg_err == 1'b1, "R5 num above 64", int'(cfg_err), 1);
    do_load(2, 0, 0, 65);
    check(cfg_err == 1'b1, "R5 den above 64", int'(cfg_err), 1);
    do_load(3, 0, 5, 3);
    check(cfg_err == 1'b1, "R5 num above den", int'(cfg_err), 1);
    run_periods(1, 1, 4, total, first);
    check(total == 16, "R5 refused settings unused", total, 16);

    // R7: load right after a tick; the running 4-pulse period finishes first
    cfg_src_sel = 1; cfg_int = 0; cfg_num = 0; cfg_den = 0; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    cyc = 1;
    if (tick) cyc = 0;
    while (!tick && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 4, "R7 old period kept", cyc, 4);
    @(negedge clk);
    check(tick == 1'b1, "R7 new spacing one", int'(tick), 1);
    check(cfg_err == 1'b0, "R6 err cleared by valid load", int'(cfg_err), 0);

    // R8: accumulator cleared by a load
    src_off(2);
    do_load(1, 2, 1, 2);
    run_periods(1, 1, 2, total, first);
    check(first == 3, "R3 short period first", first, 3);
    check(total == 7, "R3 short then long", total, 7);
    src_off(2);
    do_load(1, 2, 1, 2);
    run_periods(1, 1, 1, total, first);
    check(total == 3, "R8 remainder cleared", total, 3);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule